// File: doc/BRIEF.md
# Interrupt State Register Bank

This block keeps the configuration and live state of every shared peripheral interrupt (identifiers from 32 up to `NUM_IRQ-1`) of an interrupt distributor. Each interrupt has the following state:

- an enable bit, a pending bit and an active bit;
- an 8-bit priority;
- a trigger mode (edge or level);
- a group bit and a group-modifier bit;
- a two-bit non-secure access level.

All of it is presented in parallel, from registers, to the arbitration logic next to the block.

Software reaches the state through a single-cycle register bus. The bus carries an address, write data, a byte-size code and a secure flag. Each kind of state sits in its own address window. Enable, pending and active each have a set window and a clear window. Priority has one byte per interrupt. Trigger mode has a two-bit field per interrupt. Group, modifier and access level each have a window of their own.

When security is enabled (`sec_disable` low), a non-secure access is filtered per interrupt:

- It may only touch interrupts that are non-secure group 1, unless that interrupt's access level grants the pending or active windows.
- It sees priorities in a halved, shifted form.

Peripheral lines can also set and clear pending bits directly through per-interrupt strobes.

Top module: `irq_state_bank`

## Requirements
- R1: After a synchronous reset every implemented interrupt reads back as disabled, not pending, not active, level-triggered, priority 0xAA, with group, modifier and access level all zero.
- R2: The set-enable window (0x100) and clear-enable window (0x180) map data bit n to identifier first+n, where first = (addr - base) * 8. A 1 sets the bit (or clears it), a 0 leaves it alone, and reads of either window return the current enables.
- R3: Set-pending 0x200, clear-pending 0x280, set-active 0x300 and clear-active 0x380 follow the same bit mapping and set/clear rules for the pending and active bits.
- R4: The size code selects the access width: 0 is one byte, 1 is two bytes, 2 or 3 is four bytes. Data is right-aligned, so bit 0 of the data belongs to the first identifier. Interrupts outside the width are untouched.
- R5: The priority window (0x400) holds one byte per interrupt. Identifier first = addr - 0x400 sits in data bits 7:0, and the next identifiers take the following bytes.
- R6: The trigger window (0xC00) holds two bits per interrupt, with first = (addr - 0xC00) * 4. The upper bit of each field selects edge (1) or level (0). The lower bit always reads 0.
- R7: An access whose first identifier is below 32 reads 0 in full and changes nothing, even for lanes that reach 32 or more.
- R8: Identifiers at or above `NUM_IRQ` read 0 and ignore writes.
- R9: With security enabled, non-secure accesses to the group (0x080), modifier (0xD00) and access-level (0xE00) windows read 0 and are ignored. The access-level window has first = (addr - 0xE00) * 4 and a two-bit field per interrupt.
- R10: With security enabled, a non-secure access to an interrupt that is not non-secure group 1 (group bit 1 and modifier 0) is filtered per bit:
  - enable, trigger and priority lanes read 0 and are ignored;
  - set-pending needs access level 1 or more;
  - clear-pending and both active windows need level 2 or more.
- R11: With security enabled, a non-secure priority read returns the stored byte shifted left by one and truncated to 8 bits. A non-secure priority write stores 0x80 OR the written byte shifted right by one.
- R12: The hardware strobes `hw_pend_set`/`hw_pend_clr` change a pending bit in the next cycle. Precedence is: a bus write to that bit first, then the set strobe, then the clear strobe.
- R13: A read request gives `bus_rvalid` and `bus_rdata` in the following cycle. A write gives no `bus_rvalid`, and its effect is visible on the state outputs one cycle after the request.
- R14: With `sec_disable` high, non-secure accesses act as secure ones: no filtering and no priority shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset into the register space |
| bus_size | input | 2 | Width code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| bus_secure | input | 1 | Access is secure |
| bus_wdata | input | 32 | Write data, right-aligned |
| sec_disable | input | 1 | 1 = single security state, no filtering |
| hw_pend_set | input | NUM_IRQ | Per-identifier pending set strobes |
| hw_pend_clr | input | NUM_IRQ | Per-identifier pending clear strobes |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| irq_enabled | output | NUM_IRQ | Enable bit per identifier |
| irq_pending | output | NUM_IRQ | Pending bit per identifier |
| irq_active | output | NUM_IRQ | Active bit per identifier |
| irq_group | output | NUM_IRQ | Group bit per identifier |
| irq_grpmod | output | NUM_IRQ | Group modifier bit per identifier |
| irq_edge | output | NUM_IRQ | 1 = edge-triggered |
| irq_prio | output | NUM_IRQ*8 | Priority byte per identifier, identifier k at bits 8k+7:8k |

## Verification
The assertions take for granted that `bus_req` is held for one cycle per access and that `bus_we`, `bus_addr`, `bus_size`, `bus_secure` and `bus_wdata` are stable while it is high. They also rely on `sec_disable` changing only while no request is outstanding, since the group-lock and strobe properties relate the cycle after an access to the security state sampled with it. The stimulus drives every input on the falling edge, pulses `bus_req` for exactly one cycle, and changes `sec_disable` only between accesses. Outside the one scenario that deliberately collides a bus write with a strobe, hardware strobes are only raised in cycles with no bus request.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  localparam int SPI_BASE = 32;
  localparam int FID_W    = 12;
  localparam logic [7:0] PRIO_RST = 8'hAA;

  localparam logic [11:0] OFS_GRP  = 12'h080;
  localparam logic [11:0] OFS_SEN  = 12'h100;
  localparam logic [11:0] OFS_CEN  = 12'h180;
  localparam logic [11:0] OFS_SPND = 12'h200;
  localparam logic [11:0] OFS_CPND = 12'h280;
  localparam logic [11:0] OFS_SACT = 12'h300;
  localparam logic [11:0] OFS_CACT = 12'h380;
  localparam logic [11:0] OFS_PRIO = 12'h400;
  localparam logic [11:0] OFS_CFG  = 12'hC00;
  localparam logic [11:0] OFS_GMOD = 12'hD00;
  localparam logic [11:0] OFS_NSAC = 12'hE00;

  typedef enum logic [3:0] {
    W_NONE, W_GRP, W_SEN, W_CEN, W_SPND, W_CPND,
    W_SACT, W_CACT, W_PRIO, W_CFG, W_GMOD, W_NSAC
  } win_e;

  typedef struct packed {
    logic             valid;
    logic             we;
    win_e             win;
    logic [FID_W-1:0] first;
    logic [FID_W-1:0] units;
    logic             secure;
    logic [31:0]      wdata;
  } acc_t;

endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              secure,
  input  logic [31:0]       wdata,
  output acc_t              acc
);

  function automatic logic inside_win(input logic [ADDR_W-1:0] a,
                                      input logic [11:0] lo,
                                      input logic [11:0] len);
    return (a >= ADDR_W'(lo)) && (a < ADDR_W'(lo) + ADDR_W'(len));
  endfunction

  win_e              win;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off;
  logic [FID_W-1:0]  first;
  logic [FID_W-1:0]  nbytes;
  logic [FID_W-1:0]  units;

  always_comb begin
    win  = W_NONE;
    base = '0;
    if      (inside_win(addr, OFS_GRP,  12'h080)) begin win = W_GRP;  base = ADDR_W'(OFS_GRP);  end
    else if (inside_win(addr, OFS_SEN,  12'h080)) begin win = W_SEN;  base = ADDR_W'(OFS_SEN);  end
    else if (inside_win(addr, OFS_CEN,  12'h080)) begin win = W_CEN;  base = ADDR_W'(OFS_CEN);  end
    else if (inside_win(addr, OFS_SPND, 12'h080)) begin win = W_SPND; base = ADDR_W'(OFS_SPND); end
    else if (inside_win(addr, OFS_CPND, 12'h080)) begin win = W_CPND; base = ADDR_W'(OFS_CPND); end
    else if (inside_win(addr, OFS_SACT, 12'h080)) begin win = W_SACT; base = ADDR_W'(OFS_SACT); end
    else if (inside_win(addr, OFS_CACT, 12'h080)) begin win = W_CACT; base = ADDR_W'(OFS_CACT); end
    else if (inside_win(addr, OFS_PRIO, 12'h400)) begin win = W_PRIO; base = ADDR_W'(OFS_PRIO); end
    else if (inside_win(addr, OFS_CFG,  12'h100)) begin win = W_CFG;  base = ADDR_W'(OFS_CFG);  end
    else if (inside_win(addr, OFS_GMOD, 12'h080)) begin win = W_GMOD; base = ADDR_W'(OFS_GMOD); end
    else if (inside_win(addr, OFS_NSAC, 12'h100)) begin win = W_NSAC; base = ADDR_W'(OFS_NSAC); end
  end

  always_comb begin
    off = addr - base;
    case (size)
      2'd0:    nbytes = FID_W'(1);
      2'd1:    nbytes = FID_W'(2);
      default: nbytes = FID_W'(4);
    endcase
    case (win)
      W_NONE: begin
        first = '0;
        units = '0;
      end
      W_PRIO: begin
        first = FID_W'(off);
        units = nbytes;
      end
      W_CFG, W_NSAC: begin
        first = FID_W'(off << 2);
        units = nbytes << 2;
      end
      default: begin
        first = FID_W'(off << 3);
        units = nbytes << 3;
      end
    endcase
  end

  always_comb begin
    acc.valid  = req && (win != W_NONE) && (first >= FID_W'(SPI_BASE));
    acc.we     = we;
    acc.win    = win;
    acc.first  = first;
    acc.units  = units;
    acc.secure = secure;
    acc.wdata  = wdata;
  end

endmodule

// File: rtl/irq_bank_slot.sv
module irq_bank_slot
  import irq_bank_pkg::*;
#(
  parameter int ID = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  acc_t        acc,
  input  logic        sec_disable,
  input  logic        hw_set,
  input  logic        hw_clr,
  output logic        en_o,
  output logic        pend_o,
  output logic        act_o,
  output logic        grp_o,
  output logic        mod_o,
  output logic        edge_o,
  output logic [7:0]  prio_o,
  output logic [31:0] rd_o
);

  localparam logic [FID_W-1:0] MY_ID = FID_W'(ID);

  logic [1:0]       nsac_q;
  logic [FID_W-1:0] pos;
  logic             hit, ns_view, is_g1ns, sec_tgt, allow, ok, wr;
  logic [4:0]       bidx, cidx, nidx, pidx;
  logic             wbit;
  logic [7:0]       wbyte, prio_new, prio_view;
  logic             bus_set, bus_clr, pend_nxt;

  always_comb begin
    pos     = MY_ID - acc.first;
    hit     = acc.valid && (MY_ID >= acc.first) && (pos < acc.units);
    ns_view = !sec_disable && !acc.secure;
    is_g1ns = grp_o && !mod_o;
    sec_tgt = ns_view && !is_g1ns;
    case (acc.win)
      W_GRP, W_GMOD, W_NSAC:   allow = !ns_view;
      W_SEN, W_CEN, W_CFG,
      W_PRIO:                  allow = !sec_tgt;
      W_SPND:                  allow = !sec_tgt || (nsac_q != 2'd0);
      W_CPND, W_SACT, W_CACT:  allow = !sec_tgt || nsac_q[1];
      default:                 allow = 1'b0;
    endcase
    ok        = hit && allow;
    wr        = ok && acc.we;
    bidx      = pos[4:0];
    cidx      = {pos[3:0], 1'b1};
    nidx      = {pos[3:0], 1'b0};
    pidx      = {pos[1:0], 3'b000};
    wbit      = acc.wdata[bidx];
    wbyte     = acc.wdata[pidx +: 8];
    prio_new  = ns_view ? {1'b1, wbyte[7:1]} : wbyte;
    prio_view = ns_view ? {prio_o[6:0], 1'b0} : prio_o;
  end

  always_comb begin
    rd_o = '0;
    if (ok) begin
      case (acc.win)
        W_GRP:          rd_o = 32'(grp_o) << bidx;
        W_SEN, W_CEN:   rd_o = 32'(en_o) << bidx;
        W_SPND, W_CPND: rd_o = 32'(pend_o) << bidx;
        W_SACT, W_CACT: rd_o = 32'(act_o) << bidx;
        W_PRIO:         rd_o = 32'(prio_view) << pidx;
        W_CFG:          rd_o = 32'(edge_o) << cidx;
        W_GMOD:         rd_o = 32'(mod_o) << bidx;
        W_NSAC:         rd_o = 32'(nsac_q) << nidx;
        default:        rd_o = '0;
      endcase
    end
  end

  // bus write beats hardware strobes; set strobe beats clear strobe
  always_comb begin
    bus_set = wr && (acc.win == W_SPND) && wbit;
    bus_clr = wr && (acc.win == W_CPND) && wbit;
    if (bus_set)      pend_nxt = 1'b1;
    else if (bus_clr) pend_nxt = 1'b0;
    else if (hw_set)  pend_nxt = 1'b1;
    else if (hw_clr)  pend_nxt = 1'b0;
    else              pend_nxt = pend_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o   <= 1'b0;
      pend_o <= 1'b0;
      act_o  <= 1'b0;
      grp_o  <= 1'b0;
      mod_o  <= 1'b0;
      edge_o <= 1'b0;
      prio_o <= PRIO_RST;
      nsac_q <= 2'd0;
    end else begin
      pend_o <= pend_nxt;
      if (wr) begin
        case (acc.win)
          W_GRP:  grp_o <= wbit;
          W_SEN:  if (wbit) en_o <= 1'b1;
          W_CEN:  if (wbit) en_o <= 1'b0;
          W_SACT: if (wbit) act_o <= 1'b1;
          W_CACT: if (wbit) act_o <= 1'b0;
          W_PRIO: prio_o <= prio_new;
          W_CFG:  edge_o <= acc.wdata[cidx];
          W_GMOD: mod_o <= wbit;
          W_NSAC: nsac_q <= acc.wdata[nidx +: 2];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_bank_rdmux.sv
module irq_bank_rdmux #(
  parameter int N = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_req,
  input  logic [N-1:0][31:0]  words,
  output logic                rvalid,
  output logic [31:0]         rdata
);

  logic [31:0] merged;

  always_comb begin
    merged = '0;
    for (int i = 0; i < N; i++) merged = merged | words[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_req;
      rdata  <= rd_req ? merged : '0;
    end
  end

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [1:0]           bus_size,
  input  logic                 bus_secure,
  input  logic [31:0]          bus_wdata,
  input  logic                 sec_disable,
  input  logic [NUM_IRQ-1:0]   hw_pend_set,
  input  logic [NUM_IRQ-1:0]   hw_pend_clr,
  output logic                 bus_rvalid,
  output logic [31:0]          bus_rdata,
  output logic [NUM_IRQ-1:0]   irq_enabled,
  output logic [NUM_IRQ-1:0]   irq_pending,
  output logic [NUM_IRQ-1:0]   irq_active,
  output logic [NUM_IRQ-1:0]   irq_group,
  output logic [NUM_IRQ-1:0]   irq_grpmod,
  output logic [NUM_IRQ-1:0]   irq_edge,
  output logic [NUM_IRQ*8-1:0] irq_prio
);

  localparam int NUM_SPI = NUM_IRQ - SPI_BASE;

  initial begin
    if (NUM_IRQ <= SPI_BASE || NUM_IRQ > 1020 || ADDR_W < 12)
      $error("irq_state_bank: unsupported parameters");
  end

  acc_t                     acc;
  logic [NUM_SPI-1:0][31:0] words;
  logic                     unused_low;

  irq_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req    (bus_req),
    .we     (bus_we),
    .addr   (bus_addr),
    .size   (bus_size),
    .secure (bus_secure),
    .wdata  (bus_wdata),
    .acc    (acc)
  );

  generate
    for (genvar i = 0; i < NUM_SPI; i++) begin : g_slot
      irq_bank_slot #(.ID(SPI_BASE + i)) u_slot (
        .clk         (clk),
        .rst         (rst),
        .acc         (acc),
        .sec_disable (sec_disable),
        .hw_set      (hw_pend_set[SPI_BASE+i]),
        .hw_clr      (hw_pend_clr[SPI_BASE+i]),
        .en_o        (irq_enabled[SPI_BASE+i]),
        .pend_o      (irq_pending[SPI_BASE+i]),
        .act_o       (irq_active[SPI_BASE+i]),
        .grp_o       (irq_group[SPI_BASE+i]),
        .mod_o       (irq_grpmod[SPI_BASE+i]),
        .edge_o      (irq_edge[SPI_BASE+i]),
        .prio_o      (irq_prio[(SPI_BASE+i)*8 +: 8]),
        .rd_o        (words[i])
      );
    end
  endgenerate

  // identifiers below the shared range have no storage here
  assign irq_enabled[SPI_BASE-1:0]  = '0;
  assign irq_pending[SPI_BASE-1:0]  = '0;
  assign irq_active[SPI_BASE-1:0]   = '0;
  assign irq_group[SPI_BASE-1:0]    = '0;
  assign irq_grpmod[SPI_BASE-1:0]   = '0;
  assign irq_edge[SPI_BASE-1:0]     = '0;
  assign irq_prio[SPI_BASE*8-1:0]   = '0;
  assign unused_low = ^{hw_pend_set[SPI_BASE-1:0], hw_pend_clr[SPI_BASE-1:0]};

  irq_bank_rdmux #(.N(NUM_SPI)) u_rdmux (
    .clk    (clk),
    .rst    (rst),
    .rd_req (bus_req && !bus_we),
    .words  (words),
    .rvalid (bus_rvalid),
    .rdata  (bus_rdata)
  );

endmodule

// File: rtl/irq_state_bank_chk.sv
module irq_state_bank_chk #(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_req,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [1:0]           bus_size,
  input logic                 bus_secure,
  input logic [31:0]          bus_wdata,
  input logic                 sec_disable,
  input logic [NUM_IRQ-1:0]   hw_pend_set,
  input logic [NUM_IRQ-1:0]   hw_pend_clr,
  input logic                 bus_rvalid,
  input logic [31:0]          bus_rdata,
  input logic [NUM_IRQ-1:0]   irq_enabled,
  input logic [NUM_IRQ-1:0]   irq_pending,
  input logic [NUM_IRQ-1:0]   irq_active,
  input logic [NUM_IRQ-1:0]   irq_group,
  input logic [NUM_IRQ-1:0]   irq_grpmod,
  input logic [NUM_IRQ-1:0]   irq_edge,
  input logic [NUM_IRQ*8-1:0] irq_prio
);

  localparam logic [NUM_IRQ-1:0] SPI_MASK = {NUM_IRQ{1'b1}} << 32;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (irq_enabled == '0 && irq_pending == '0 && irq_active == '0));

  // R13
  a_r13_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> bus_rvalid);

  a_r13_rvalid_only_for_read: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_req && !bus_we));

  // R12
  a_r12_hw_set_lands: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> ((irq_pending & $past(hw_pend_set & SPI_MASK)) == $past(hw_pend_set & SPI_MASK)));

  // R2
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> ($stable(irq_enabled) && $stable(irq_active) && $stable(irq_prio) && $stable(irq_edge)));

  // R9
  a_r9_ns_group_locked: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && !bus_secure && !sec_disable) |=> ($stable(irq_group) && $stable(irq_grpmod)));

endmodule

bind irq_state_bank irq_state_bank_chk #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/irq_state_bank_tb.sv
module irq_state_bank_tb;

  localparam int NUM_IRQ = 64;
  localparam int ADDR_W  = 12;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 bus_req = 1'b0;
  logic                 bus_we = 1'b0;
  logic [ADDR_W-1:0]    bus_addr = '0;
  logic [1:0]           bus_size = 2'd2;
  logic                 bus_secure = 1'b1;
  logic [31:0]          bus_wdata = '0;
  logic                 sec_disable = 1'b0;
  logic [NUM_IRQ-1:0]   hw_pend_set = '0;
  logic [NUM_IRQ-1:0]   hw_pend_clr = '0;
  logic                 bus_rvalid;
  logic [31:0]          bus_rdata;
  logic [NUM_IRQ-1:0]   irq_enabled, irq_pending, irq_active;
  logic [NUM_IRQ-1:0]   irq_group, irq_grpmod, irq_edge;
  logic [NUM_IRQ*8-1:0] irq_prio;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  irq_state_bank #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [1:0] sz, input logic sec, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = sz; bus_secure = sec; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] sz, input logic sec, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz; bus_secure = sec;
    @(negedge clk);
    d = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
    bus_req = 1'b0;
  endtask

  function automatic logic [7:0] prio_of(input int id);
    return irq_prio[id*8 +: 8];
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h104, 2'd2, 1'b1, d); chk("R1 enables", d, 32'h0);
    rd(12'h420, 2'd2, 1'b1, d); chk("R1 priorities", d, 32'hAAAA_AAAA);
    rd(12'hC08, 2'd2, 1'b1, d); chk("R1 trigger", d, 32'h0);
    chk("R1 pending out", irq_pending[63:32], 32'h0);
    chk("R1 prio out", {24'h0, prio_of(63)}, 32'hAA);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(12'h104, 2'd2, 1'b1, 32'h0000_00F5);
    chk("R2 set-enable", irq_enabled[63:32], 32'h0000_00F5);
    rd(12'h184, 2'd2, 1'b1, d); chk("R2 clear window reads state", d, 32'h0000_00F5);
    wr(12'h184, 2'd2, 1'b1, 32'h0000_0005);
    chk("R2 clear-enable", irq_enabled[63:32], 32'h0000_00F0);
    wr(12'h104, 2'd2, 1'b1, 32'h0);
    chk("R2 zero no effect", irq_enabled[63:32], 32'h0000_00F0);
    @(negedge clk);
    chk("R13 no rvalid on write", {31'h0, bus_rvalid}, 32'h0);
  endtask

  task automatic t_size;
    logic [31:0] d;
    wr(12'h105, 2'd0, 1'b1, 32'hFFFF_FFFF);
    chk("R4 byte write", irq_enabled[63:32], 32'h0000_FFF0);
    wr(12'h106, 2'd1, 1'b1, 32'hFFFF_FFFF);
    rd(12'h104, 2'd2, 1'b1, d); chk("R4 half write", d, 32'hFFFF_FFF0);
  endtask

  task automatic t_pend_act;
    logic [31:0] d;
    wr(12'h204, 2'd2, 1'b1, 32'h3);
    wr(12'h284, 2'd2, 1'b1, 32'h1);
    chk("R3 pending set/clear", irq_pending[63:32], 32'h2);
    wr(12'h304, 2'd2, 1'b1, 32'h10);
    rd(12'h384, 2'd2, 1'b1, d); chk("R3 active readback", d, 32'h10);
    wr(12'h384, 2'd2, 1'b1, 32'h10);
    chk("R3 active clear", irq_active[63:32], 32'h0);
  endtask

  task automatic t_prio;
    logic [31:0] d;
    wr(12'h420, 2'd2, 1'b1, 32'h1122_3344);
    chk("R5 prio id32", {24'h0, prio_of(32)}, 32'h44);
    chk("R5 prio id35", {24'h0, prio_of(35)}, 32'h11);
    wr(12'h425, 2'd0, 1'b1, 32'h0000_0077);
    rd(12'h424, 2'd2, 1'b1, d); chk("R5 byte lanes", d, 32'hAAAA_77AA);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wr(12'hC08, 2'd2, 1'b1, 32'hFFFF_FFFF);
    chk("R6 edge bits", irq_edge[63:32], 32'h0000_FFFF);
    rd(12'hC08, 2'd2, 1'b1, d); chk("R6 lower bit zero", d, 32'hAAAA_AAAA);
  endtask

  task automatic t_bounds;
    logic [31:0] d;
    wr(12'h100, 2'd2, 1'b1, 32'hFFFF_FFFF);
    rd(12'h100, 2'd2, 1'b1, d); chk("R7 low ids read zero", d, 32'h0);
    wr(12'h41E, 2'd2, 1'b1, 32'hFFFF_FFFF);
    chk("R7 straddling write ignored", {24'h0, prio_of(32)}, 32'h44);
    rd(12'h41E, 2'd2, 1'b1, d); chk("R7 straddling read zero", d, 32'h0);
    wr(12'h108, 2'd2, 1'b1, 32'hFFFF_FFFF);
    rd(12'h108, 2'd2, 1'b1, d); chk("R8 above count", d, 32'h0);
    chk("R8 in-range untouched", irq_enabled[63:32], 32'hFFFF_FFF0);
  endtask

  task automatic t_ns_groups;
    logic [31:0] d;
    wr(12'h084, 2'd2, 1'b0, 32'hFFFF_FFFF);
    chk("R9 ns group write ignored", irq_group[63:32], 32'h0);
    wr(12'h084, 2'd2, 1'b1, 32'h0000_000F);
    wr(12'hD04, 2'd2, 1'b1, 32'h0000_0002);
    rd(12'h084, 2'd2, 1'b0, d); chk("R9 ns group read zero", d, 32'h0);
    rd(12'h084, 2'd2, 1'b1, d); chk("R9 secure group read", d, 32'hF);
    wr(12'hE08, 2'd2, 1'b1, 32'h0000_0900);
    rd(12'hE08, 2'd2, 1'b0, d); chk("R9 ns access-level read zero", d, 32'h0);
    rd(12'hE08, 2'd2, 1'b1, d); chk("R9 access-level readback", d, 32'h0000_0900);
  endtask

  task automatic t_ns_filter;
    logic [31:0] d;
    wr(12'h104, 2'd2, 1'b0, 32'hFFFF_FFFF);
    chk("R10 ns enable only g1ns", irq_enabled[63:32], 32'hFFFF_FFFD);
    rd(12'h104, 2'd2, 1'b0, d); chk("R10 ns enable view", d, 32'h0000_000D);
    wr(12'h204, 2'd2, 1'b0, 32'h0000_00F0);
    chk("R10 ns set-pending by level", irq_pending[63:32], 32'h32);
    wr(12'h284, 2'd2, 1'b0, 32'h0000_0030);
    chk("R10 ns clear-pending by level", irq_pending[63:32], 32'h12);
    wr(12'h304, 2'd2, 1'b0, 32'h0000_0030);
    chk("R10 ns set-active by level", irq_active[63:32], 32'h20);
    wr(12'hC08, 2'd2, 1'b0, 32'h0);
    chk("R10 ns trigger only g1ns", irq_edge[63:32], 32'h0000_FFF2);
  endtask

  task automatic t_ns_prio;
    logic [31:0] d;
    rd(12'h422, 2'd0, 1'b0, d); chk("R11 ns prio read shift", d, 32'h44);
    wr(12'h422, 2'd0, 1'b0, 32'h60);
    chk("R11 ns prio write", {24'h0, prio_of(34)}, 32'hB0);
    rd(12'h422, 2'd0, 1'b0, d); chk("R11 ns prio truncate", d, 32'h60);
    wr(12'h421, 2'd0, 1'b0, 32'h0);
    chk("R10 ns prio secure id kept", {24'h0, prio_of(33)}, 32'h33);
    rd(12'h421, 2'd0, 1'b0, d); chk("R10 ns prio secure read zero", d, 32'h0);
  endtask

  task automatic t_secdis;
    logic [31:0] d;
    @(negedge clk); sec_disable = 1'b1;
    wr(12'h084, 2'd2, 1'b0, 32'h1);
    chk("R14 ns group write", irq_group[63:32], 32'h1);
    wr(12'h204, 2'd2, 1'b0, 32'h40);
    chk("R14 ns set-pending", irq_pending[63:32], 32'h52);
    wr(12'h426, 2'd0, 1'b0, 32'h5A);
    rd(12'h426, 2'd0, 1'b0, d); chk("R14 no prio shift", d, 32'h5A);
    @(negedge clk); sec_disable = 1'b0;
  endtask

  task automatic t_hw;
    @(negedge clk); hw_pend_set[40] = 1'b1;
    @(negedge clk); hw_pend_set[40] = 1'b0;
    chk("R12 hw set", {31'h0, irq_pending[40]}, 32'h1);
    hw_pend_set[41] = 1'b1; hw_pend_clr[41] = 1'b1;
    @(negedge clk); hw_pend_set[41] = 1'b0; hw_pend_clr[41] = 1'b0;
    chk("R12 set beats clear", {31'h0, irq_pending[41]}, 32'h1);
    hw_pend_clr[40] = 1'b1;
    @(negedge clk); hw_pend_clr[40] = 1'b0;
    chk("R12 hw clear", {31'h0, irq_pending[40]}, 32'h0);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h285; bus_size = 2'd0;
    bus_secure = 1'b1; bus_wdata = 32'h2; hw_pend_set[41] = 1'b1;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; hw_pend_set[41] = 1'b0;
    chk("R12 bus beats hw", {31'h0, irq_pending[41]}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_enable;
    t_size;
    t_pend_act;
    t_prio;
    t_cfg;
    t_bounds;
    t_ns_groups;
    t_ns_filter;
    t_ns_prio;
    t_secdis;
    t_hw;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule